// File: doc/BRIEF.md
# Software Alert and NMI Controller

This block turns register writes from software into alert requests, one per alert class, and collects two non-maskable interrupt sources (an alert source and a watchdog source) into a single interrupt request. Software uses a small word-indexed register port. It can fire a one-shot test event for any of the four alert classes. It can also arm two 4-bit redundant-boolean triggers. The recoverable trigger disarms itself once its alert has been delivered. The fatal trigger stays armed until reset.

Each alert class keeps its request line high until the alert transport acknowledges it. One acknowledged request counts as one alert event. The NMI side latches raw events into state bits, and software clears those bits by writing 1. The state bits are gated by enable bits that can only ever be set. The gated result is combined and driven out through a register.

Redundant booleans use 4'h9 as the false code and 4'h6 as the canonical true code. Every code other than 4'h9 counts as true, so a single flipped bit cannot make a request disappear.

Top module: `sac_swalert_nmi`

## Requirements
- R1: After reset, index 1 and index 2 read 4'h9, index 3 and index 4 read 0, every alert request is low and the NMI request is low.
- R2: A write to index 0 raises exactly one alert event for each data bit set to 1. The class is set by the bit position: bit 0 fatal software, bit 1 recoverable software, bit 2 fatal hardware, bit 3 recoverable hardware. Index 0 always reads 0.
- R3: An alert request stays high until its class acknowledge is sampled high together with it. Each such handshake counts as one event.
- R4: Index 1 (recoverable trigger) is freely writable. Any stored value other than 4'h9, including 4'h0, raises a recoverable-software alert (class bit 1). Writing 4'h9 raises none.
- R5: The recoverable trigger keeps its written value while its alert is pending. It returns to 4'h9 in the cycle its alert is acknowledged.
- R6: Index 2 (fatal trigger) is write-1-to-set: the new value is the old value OR the written data. A write that leaves it at 4'h9 raises no alert.
- R7: Once the fatal trigger holds a value other than 4'h9, it raises fatal-software events one after another. No write brings it back to 4'h9.
- R8: Index 3 holds the NMI enables, bit 0 for the alert source and bit 1 for the watchdog source. Writing 1 sets a bit. No write clears one.
- R9: Index 4 holds the NMI state, bit 0 alert and bit 1 watchdog. A raw event sets its bit and writing 1 clears it. When an event and a clear land in the same cycle, the event wins.
- R10: The NMI request equals the OR over sources of state AND enable, registered: it changes one cycle after the state or enable change.
- R11: Indices other than 0 to 4 read 0. Writes to them change no register and raise no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Word index of the write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | ADDR_W | Word index of the read |
| reg_rdata_o | output | DATA_W | Read data (combinational) |
| alert_ack_i | input | 4 | Per-class acknowledge from the alert transport |
| nmi_alert_evt_i | input | 1 | Raw alert NMI event |
| nmi_wdog_evt_i | input | 1 | Raw watchdog NMI event |
| alert_req_o | output | 4 | Per-class alert request |
| nmi_req_o | output | 1 | Combined NMI request |

## Verification
The bench builds the block with DATA_W = 32 and widens ADDR_W from 3 to 4. With a 4-bit index the bench can address index 9, whose low three bits alias the recoverable trigger. That makes the rule that unused indices are ignored observable: a decoder that drops the upper index bit would arm the trigger and fire an alert. The alert transport is modelled with an acknowledge latency of three cycles. A per-class hold mask lets the bench stall a request, so it can observe both the held request and the recoverable value kept while pending.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int MUBI_W = 4;
    typedef logic [MUBI_W-1:0] mubi4_t;

    localparam mubi4_t MUBI4_FALSE = 4'h9;
    localparam mubi4_t MUBI4_TRUE  = 4'h6;

    localparam int NUM_ALERTS = 4;
    localparam int NUM_NMI    = 2;

    // Alert class positions (bit order of the test register)
    localparam int ACLS_FATAL_SW = 0;
    localparam int ACLS_RECOV_SW = 1;
    localparam int ACLS_FATAL_HW = 2;
    localparam int ACLS_RECOV_HW = 3;

    // NMI source positions
    localparam int NSRC_ALERT = 0;
    localparam int NSRC_WDOG  = 1;

    // Register word indices
    localparam int RIDX_ATEST  = 0;
    localparam int RIDX_RECOV  = 1;
    localparam int RIDX_FATAL  = 2;
    localparam int RIDX_NMI_EN = 3;
    localparam int RIDX_NMI_ST = 4;

    typedef struct packed {
        logic atest;
        logic recov;
        logic fatal;
        logic nmi_en;
        logic nmi_st;
    } wr_sel_t;

    function automatic logic mubi4_is_true(mubi4_t v);
        return v != MUBI4_FALSE;
    endfunction

    function automatic mubi4_t mubi4_set(mubi4_t cur, mubi4_t setbits);
        return cur | setbits;
    endfunction

endpackage

// File: rtl/sac_reg_decode.sv
module sac_reg_decode
    import sac_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_sel_t           sel_o
);

    localparam logic [ADDR_W-1:0] A_ATEST  = ADDR_W'(RIDX_ATEST);
    localparam logic [ADDR_W-1:0] A_RECOV  = ADDR_W'(RIDX_RECOV);
    localparam logic [ADDR_W-1:0] A_FATAL  = ADDR_W'(RIDX_FATAL);
    localparam logic [ADDR_W-1:0] A_NMI_EN = ADDR_W'(RIDX_NMI_EN);
    localparam logic [ADDR_W-1:0] A_NMI_ST = ADDR_W'(RIDX_NMI_ST);

    always_comb begin
        sel_o        = '0;
        sel_o.atest  = we_i && (addr_i == A_ATEST);
        sel_o.recov  = we_i && (addr_i == A_RECOV);
        sel_o.fatal  = we_i && (addr_i == A_FATAL);
        sel_o.nmi_en = we_i && (addr_i == A_NMI_EN);
        sel_o.nmi_st = we_i && (addr_i == A_NMI_ST);
    end

    always_comb begin
        assert ($countones(sel_o) <= 1) else $error("AST_ONE_WRITE_TARGET");  // R11
    end

endmodule

// File: rtl/sac_sw_alert_regs.sv
module sac_sw_alert_regs
    import sac_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   wr_recov_i,
    input  logic   wr_fatal_i,
    input  mubi4_t wdata_i,
    input  logic   recov_sent_i,
    output mubi4_t recov_q_o,
    output mubi4_t fatal_q_o
);

    mubi4_t recov_q, fatal_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            recov_q <= MUBI4_FALSE;
        end else if (wr_recov_i) begin
            recov_q <= wdata_i;
        end else if (recov_sent_i) begin
            recov_q <= MUBI4_FALSE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fatal_q <= MUBI4_FALSE;
        end else if (wr_fatal_i) begin
            fatal_q <= mubi4_set(fatal_q, wdata_i);
        end
    end

    assign recov_q_o = recov_q;
    assign fatal_q_o = fatal_q;

    AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (fatal_q != MUBI4_FALSE) |=> (fatal_q != MUBI4_FALSE))
        else $error("AST_FATAL_STICKY");  // R7

    AST_RECOV_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (recov_sent_i && !wr_recov_i) |=> (recov_q == MUBI4_FALSE))
        else $error("AST_RECOV_SELF_CLEAR");  // R5

    AST_RECOV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!recov_sent_i && !wr_recov_i) |=> $stable(recov_q))
        else $error("AST_RECOV_HOLD");  // R5

endmodule

// File: rtl/sac_alert_chan.sv
module sac_alert_chan (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_pulse_i,
    input  logic trig_level_i,
    input  logic ack_i,
    output logic req_o
);

    logic req_q, req_d;

    // A pending request absorbs new triggers. After a handshake a one-shot
    // trigger in the same cycle re-arms at once; a level re-arms one cycle later.
    always_comb begin
        if (req_q) begin
            req_d = !ack_i || trig_pulse_i;
        end else begin
            req_d = trig_pulse_i || trig_level_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_o = req_q;

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_o && !ack_i) |=> req_o)
        else $error("AST_REQ_HOLD");  // R3

    AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!req_o && !trig_pulse_i && !trig_level_i) |=> !req_o)
        else $error("AST_REQ_CAUSE");  // R2

endmodule

// File: rtl/sac_nmi_track.sv
module sac_nmi_track #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         set_en_i,
    input  logic         clr_st_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] st_o,
    output logic         nmi_o
);

    logic [N-1:0] en_q, st_q;
    logic [N-1:0] clr_mask;
    logic         nmi_q;

    assign clr_mask = clr_st_i ? wdata_i : '0;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                en_q[i] <= 1'b0;
                st_q[i] <= 1'b0;
            end else begin
                en_q[i] <= en_q[i] | (set_en_i & wdata_i[i]);
                st_q[i] <= evt_i[i] | (st_q[i] & ~clr_mask[i]);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= |(st_q & en_q);
        end
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign nmi_o = nmi_q;

    AST_NMI_EN_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (|en_o) |=> ((en_o & $past(en_o)) == $past(en_o)))
        else $error("AST_NMI_EN_STICKY");  // R8

    AST_NMI_EVT_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (|evt_i) |=> ((st_o & $past(evt_i)) == $past(evt_i)))
        else $error("AST_NMI_EVT_WINS");  // R9

    AST_NMI_ST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_st_i && (|st_o)) |=> ((st_o & $past(st_o)) == $past(st_o)))
        else $error("AST_NMI_ST_HOLD");  // R9

    AST_NMI_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_o & en_o) == '0) |=> !nmi_o)
        else $error("AST_NMI_QUIET");  // R10

endmodule

// File: rtl/sac_swalert_nmi.sv
module sac_swalert_nmi
    import sac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_waddr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    input  logic [ADDR_W-1:0]     reg_raddr_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic [NUM_ALERTS-1:0] alert_ack_i,
    input  logic                  nmi_alert_evt_i,
    input  logic                  nmi_wdog_evt_i,
    output logic [NUM_ALERTS-1:0] alert_req_o,
    output logic                  nmi_req_o
);

    localparam logic [ADDR_W-1:0] A_RECOV  = ADDR_W'(RIDX_RECOV);
    localparam logic [ADDR_W-1:0] A_FATAL  = ADDR_W'(RIDX_FATAL);
    localparam logic [ADDR_W-1:0] A_NMI_EN = ADDR_W'(RIDX_NMI_EN);
    localparam logic [ADDR_W-1:0] A_NMI_ST = ADDR_W'(RIDX_NMI_ST);

    wr_sel_t                wr_sel;
    mubi4_t                 recov_q, fatal_q;
    logic [NUM_ALERTS-1:0]  req_vec;
    logic [NUM_ALERTS-1:0]  lvl_vec;
    logic [NUM_NMI-1:0]     nmi_evt, nmi_en, nmi_st;
    logic                   recov_sent;
    logic                   unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_ALERTS];

    sac_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .we_i   (reg_we_i),
        .addr_i (reg_waddr_i),
        .sel_o  (wr_sel)
    );

    assign recov_sent = alert_ack_i[ACLS_RECOV_SW] & req_vec[ACLS_RECOV_SW];

    sac_sw_alert_regs u_swregs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_recov_i   (wr_sel.recov),
        .wr_fatal_i   (wr_sel.fatal),
        .wdata_i      (reg_wdata_i[MUBI_W-1:0]),
        .recov_sent_i (recov_sent),
        .recov_q_o    (recov_q),
        .fatal_q_o    (fatal_q)
    );

    always_comb begin
        lvl_vec                = '0;
        lvl_vec[ACLS_FATAL_SW] = mubi4_is_true(fatal_q);
        lvl_vec[ACLS_RECOV_SW] = mubi4_is_true(recov_q);
    end

    for (genvar c = 0; c < NUM_ALERTS; c++) begin : g_chan
        sac_alert_chan u_chan (
            .clk_i        (clk_i),
            .rst_i        (rst_i),
            .trig_pulse_i (wr_sel.atest & reg_wdata_i[c]),
            .trig_level_i (lvl_vec[c]),
            .ack_i        (alert_ack_i[c]),
            .req_o        (req_vec[c])
        );
    end

    always_comb begin
        nmi_evt             = '0;
        nmi_evt[NSRC_ALERT] = nmi_alert_evt_i;
        nmi_evt[NSRC_WDOG]  = nmi_wdog_evt_i;
    end

    sac_nmi_track #(.N(NUM_NMI)) u_nmi (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .set_en_i (wr_sel.nmi_en),
        .clr_st_i (wr_sel.nmi_st),
        .wdata_i  (reg_wdata_i[NUM_NMI-1:0]),
        .evt_i    (nmi_evt),
        .en_o     (nmi_en),
        .st_o     (nmi_st),
        .nmi_o    (nmi_req_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_raddr_i)
            A_RECOV:  reg_rdata_o[MUBI_W-1:0]  = recov_q;
            A_FATAL:  reg_rdata_o[MUBI_W-1:0]  = fatal_q;
            A_NMI_EN: reg_rdata_o[NUM_NMI-1:0] = nmi_en;
            A_NMI_ST: reg_rdata_o[NUM_NMI-1:0] = nmi_st;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign alert_req_o = req_vec;

    AST_FATAL_KEEPS_FIRING: assert property (@(posedge clk_i) disable iff (rst_i)
        (mubi4_is_true(fatal_q) && !req_vec[ACLS_FATAL_SW]) |=> req_vec[ACLS_FATAL_SW])
        else $error("AST_FATAL_KEEPS_FIRING");  // R7

    AST_RECOV_RAISES: assert property (@(posedge clk_i) disable iff (rst_i)
        (mubi4_is_true(recov_q) && !req_vec[ACLS_RECOV_SW]) |=> req_vec[ACLS_RECOV_SW])
        else $error("AST_RECOV_RAISES");  // R4

endmodule

// File: tb/tb_sac_swalert_nmi.sv
`timescale 1ns/1ps
module tb_sac_swalert_nmi;

    localparam int AW  = 4;
    localparam int DW  = 32;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] rdata;
    logic [3:0]    ack = '0;
    logic          evt_alert = 1'b0;
    logic          evt_wdog = 1'b0;
    logic [3:0]    req;
    logic          nmi;

    always #10 clk = ~clk;

    sac_swalert_nmi #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk_i           (clk),
        .rst_i           (rst),
        .reg_we_i        (we),
        .reg_waddr_i     (waddr),
        .reg_wdata_i     (wdata),
        .reg_raddr_i     (raddr),
        .reg_rdata_o     (rdata),
        .alert_ack_i     (ack),
        .nmi_alert_evt_i (evt_alert),
        .nmi_wdog_evt_i  (evt_wdog),
        .alert_req_o     (req),
        .nmi_req_o       (nmi)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    int   exp_q[$];
    bit   strict = 1'b1;
    int   fatal_cnt = 0;
    logic [3:0] hold = '0;
    int   wait_cnt [4];
    bit   done = 1'b0;

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; waddr = AW'(idx); wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic chk_rd(input int idx, input logic [31:0] exp, input string rq);
        @(negedge clk);
        raddr = AW'(idx);
        #2;
        check(rdata == exp, rq, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_evt(input int cls);
        exp_q.push_back(cls);
    endtask

    // Scoreboard monitor and acknowledge model (fixed latency)
    initial begin
        for (int c = 0; c < 4; c++) wait_cnt[c] = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int c = 0; c < 4; c++) begin
                    if (ack[c]) begin
                        ack[c] = 1'b0;
                        wait_cnt[c] = 0;
                    end else if (req[c] && !hold[c]) begin
                        wait_cnt[c]++;
                        if (wait_cnt[c] >= LAT) begin
                            ack[c] = 1'b1;
                            if (strict) begin
                                if (exp_q.size() == 0) begin
                                    check(1'b0, "R3 unexpected event", c, 32'hffff_ffff);
                                end else begin
                                    int e;
                                    e = exp_q.pop_front();
                                    check(e == c, "R3 event class", c, e);
                                end
                            end else if (c == 0) begin
                                fatal_cnt++;
                            end else begin
                                check(1'b0, "R7 stray class during fatal", c, 0);
                            end
                        end
                    end else begin
                        wait_cnt[c] = 0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        check(req == 4'h0, "R1 alert requests", req, 0);
        check(nmi == 1'b0, "R1 nmi request", nmi, 0);
        chk_rd(1, 32'h9, "R1 recov trigger");
        chk_rd(2, 32'h9, "R1 fatal trigger");
        chk_rd(3, 32'h0, "R1 nmi enable");
        chk_rd(4, 32'h0, "R1 nmi state");

        // R2 alert test, two classes at once
        expect_evt(1); expect_evt(3);
        wr(0, 32'hA);
        chk_rd(0, 32'h0, "R2 test reads zero");
        idle(15);
        check(exp_q.size() == 0, "R2 events delivered", exp_q.size(), 0);
        check(req == 4'h0, "R3 request drops after ack", req, 0);

        // R3 request held while ack withheld
        hold[2] = 1'b1;
        expect_evt(2);
        wr(0, 32'h4);
        idle(10);
        check(req == 4'h4, "R3 request held", req, 4'h4);
        hold[2] = 1'b0;
        idle(10);
        check(exp_q.size() == 0 && req == 4'h0, "R3 held request served", req, 0);

        // R2 all four classes
        expect_evt(0); expect_evt(1); expect_evt(2); expect_evt(3);
        wr(0, 32'hF);
        idle(15);
        check(exp_q.size() == 0, "R2 four classes", exp_q.size(), 0);

        // R4/R5 recoverable trigger with true code
        expect_evt(1);
        wr(1, 32'h6);
        idle(15);
        check(exp_q.size() == 0, "R4 recov alert sent", exp_q.size(), 0);
        chk_rd(1, 32'h9, "R5 recov back to false");

        // R4 writing false raises nothing
        wr(1, 32'h9);
        idle(12);
        check(req == 4'h0, "R4 false write quiet", req, 0);

        // R4 non-canonical true 0x0
        expect_evt(1);
        wr(1, 32'h0);
        idle(15);
        check(exp_q.size() == 0, "R4 code 0x0 counts true", exp_q.size(), 0);
        chk_rd(1, 32'h9, "R5 recov cleared after 0x0");

        // R5 value kept while pending
        hold[1] = 1'b1;
        expect_evt(1);
        wr(1, 32'h6);
        idle(6);
        chk_rd(1, 32'h6, "R5 recov kept while pending");
        hold[1] = 1'b0;
        idle(12);
        chk_rd(1, 32'h9, "R5 recov cleared on ack");

        // R6 fatal write that stays false
        wr(2, 32'h1);
        chk_rd(2, 32'h9, "R6 fatal or-set stays false");
        idle(10);
        check(req == 4'h0, "R6 no fatal alert", req, 0);

        // R11 unused index aliasing recov in its low bits
        wr(9, 32'hF);
        chk_rd(9, 32'h0, "R11 unused reads zero");
        chk_rd(1, 32'h9, "R11 recov untouched");
        idle(10);
        check(req == 4'h0, "R11 no alert from unused write", req, 0);

        // R9 NMI event sets state, enable still off
        @(negedge clk); evt_alert = 1'b1;
        @(negedge clk); evt_alert = 1'b0;
        chk_rd(4, 32'h1, "R9 alert state set");
        idle(2);
        check(nmi == 1'b0, "R10 masked nmi", nmi, 0);

        // R10 exact latency of enable to nmi
        wr(3, 32'h1);
        #1;
        check(nmi == 1'b0, "R10 nmi one cycle after enable", nmi, 0);
        @(negedge clk);
        check(nmi == 1'b1, "R10 nmi raised", nmi, 1);

        // R8 enable cannot be cleared
        wr(3, 32'h0);
        chk_rd(3, 32'h1, "R8 enable sticky");

        // R9 clear by writing 1
        wr(4, 32'h1);
        chk_rd(4, 32'h0, "R9 state cleared");
        idle(2);
        check(nmi == 1'b0, "R10 nmi drops", nmi, 0);

        // R9 event wins over clear
        @(negedge clk);
        evt_alert = 1'b1; we = 1'b1; waddr = AW'(4); wdata = 32'h1;
        @(negedge clk);
        evt_alert = 1'b0; we = 1'b0; wdata = '0;
        chk_rd(4, 32'h1, "R9 event wins");
        wr(4, 32'h1);

        // R8/R9/R10 watchdog source
        wr(3, 32'h2);
        chk_rd(3, 32'h3, "R8 both enables");
        @(negedge clk); evt_wdog = 1'b1;
        @(negedge clk); evt_wdog = 1'b0;
        idle(2);
        check(nmi == 1'b1, "R10 wdog nmi", nmi, 1);
        chk_rd(4, 32'h2, "R9 wdog state");
        wr(4, 32'h2);
        idle(2);
        check(nmi == 1'b0, "R10 wdog nmi cleared", nmi, 0);

        // R7 fatal trigger fires continuously
        check(exp_q.size() == 0, "R3 no pending expectations", exp_q.size(), 0);
        strict = 1'b0;
        fatal_cnt = 0;
        wr(2, 32'h2);
        chk_rd(2, 32'hB, "R6 fatal or-set value");
        idle(40);
        check(fatal_cnt >= 3, "R7 repeated fatal events", fatal_cnt, 3);
        wr(2, 32'h9);
        wr(2, 32'h0);
        chk_rd(2, 32'hB, "R7 fatal cannot clear");
        fatal_cnt = 0;
        idle(30);
        check(fatal_cnt >= 2, "R7 fatal still firing", fatal_cnt, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule